// File: doc/BRIEF.md
# DMA Request Edge Acceptance Controller

This block turns an asynchronous, active-low external DMA request pin into single transfer requests for one DMA channel that moves data in dual-address fashion: one read from the source, then one write to the destination. The pin first passes through a two-flop synchronizer. While acceptance is open and the channel is enabled, a sampled low level latches a pending request. At the next bus-break strobe the pending request is cleared and the channel starts its read cycle.

Once the transfer has started, the block looks for the pin to return high. It reopens acceptance only when both of these have happened: a high level has been seen after activation, and the write cycle has ended. A pin held low for a long time therefore produces exactly one transfer. After each write the bus is left released for a fixed number of idle cycles before another read may start. Clearing the enable bit drops a pending request and lets the current bus cycle end without a following one.

Top module: `dreq_accept_ctrl`

## Requirements
- R1: After reset `rd_cyc`, `wr_cyc` and `xfer_done` are 0. A falling edge on `dreq_n` reaches the acceptance logic through two synchronizer flops. With `bus_break` and `bus_grant` held at 1, `rd_cyc` first reads 1 four clock edges after the pin is driven low.
- R2: A pending request waits while `bus_break` is 0. The clock edge at which `bus_break` is 1 clears the pending request and starts the read cycle.
- R3: A transfer is one read cycle (`rd_cyc`=1) followed directly by one write cycle (`wr_cyc`=1). Each lasts CYC_LEN (default 2) clock edges at which `bus_grant` is 1. Edges with `bus_grant`=0 extend the current cycle. `rd_cyc` and `wr_cyc` are never 1 together.
- R4: `xfer_done` is 1 for exactly one clock, in the cycle immediately after the last write cycle.
- R5: After a write ends, at least REL_CYC (default 2) cycles pass with `rd_cyc`=0 before the next read begins. A request re-accepted during the write starts its read no earlier than 3 cycles after the `xfer_done` cycle.
- R6: Acceptance reopens only after a high level has been sampled since activation and the write cycle has ended. A pin held low through and after a transfer produces no second transfer until it goes high and then low again.
- R7: With `xfer_en`=0 the pin is ignored and no read cycle starts.
- R8: If `xfer_en` is cleared during a read cycle, the read completes and the channel returns to idle with no write cycle and no `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the pin is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dreq_n | input | 1 | Asynchronous active-low transfer request pin |
| xfer_en | input | 1 | Channel enable for pin activation |
| bus_grant | input | 1 | Bus owned this cycle; bus-cycle clocks advance only when 1 |
| bus_break | input | 1 | Bus-break point at which a pending request is activated |
| rd_cyc | output | 1 | Source read cycle in progress |
| wr_cyc | output | 1 | Destination write cycle in progress |
| xfer_done | output | 1 | One-clock pulse after the write cycle |

## Verification
Several properties are checked by assertions on every clock edge:
- read and write cycles never overlap;
- a read can start only after a bus-break strobe while the channel is enabled;
- the pending request is gone after activation;
- the done pulse follows a write and lasts one clock;
- two idle cycles follow every write;
- acceptance never reopens without a completed write.

Other behaviours can only be shown by the bench scenarios. These are the exact latency through the synchronizer, the stretching of a cycle by a withdrawn grant, the single transfer for a pin held low, and the abort when enable drops mid-read. The bench also confirms that a disabled channel ignores the pin.

// File: rtl/dreq_pkg.sv
// Package: shared types for the DMA request acceptance controller.
// Assumes: one channel, dual-address (read then write) transfers.
package dreq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_REL   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/dreq_sync.sv
// Module: dreq_sync
// Brings an asynchronous level into the clock domain through a chain of
// flops. Assumes the input is a slow level (no pulse shorter than a clock).
module dreq_sync #(
    parameter int    STAGES    = 2,
    parameter logic  RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    // Shift the pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], async_i};
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/dreq_accept.sv
// Module: dreq_accept
// Latches a pending request from the synchronized pin while acceptance is
// open. After activation it watches for a high level and for the end of
// the write cycle, and reopens acceptance only when both have been seen.
// Assumes act_i occurs only while pend_o is set.
module dreq_accept (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_s,
    input  logic en_i,
    input  logic idle_i,
    input  logic act_i,
    input  logic wr_end_i,
    output logic pend_o
);
    logic armed;
    logic watch;
    logic hi_seen;
    logic wr_seen;
    logic hi_nx;
    logic wr_nx;

    assign hi_nx = hi_seen | req_n_s;
    assign wr_nx = wr_seen | wr_end_i;

    // Pending request: set on a sampled low while open, dropped on activation or disable.
    always_ff @(posedge clk) begin
        if (!rst_n)                        pend_o <= 1'b0;
        else if (!en_i)                    pend_o <= 1'b0;
        else if (act_i)                    pend_o <= 1'b0;
        else if (armed && !req_n_s)        pend_o <= 1'b1;
    end

    // Acceptance window and re-arm tracking after activation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b1;
            watch   <= 1'b0;
            hi_seen <= 1'b0;
            wr_seen <= 1'b0;
        end else if (!en_i && idle_i) begin
            armed   <= 1'b1;
            watch   <= 1'b0;
            hi_seen <= 1'b0;
            wr_seen <= 1'b0;
        end else if (en_i && armed && !req_n_s) begin
            armed   <= 1'b0;
        end else if (act_i) begin
            watch   <= 1'b1;
            hi_seen <= 1'b0;
            wr_seen <= 1'b0;
        end else if (watch) begin
            if (hi_nx && wr_nx) begin
                armed   <= 1'b1;
                watch   <= 1'b0;
                hi_seen <= 1'b0;
                wr_seen <= 1'b0;
            end else begin
                hi_seen <= hi_nx;
                wr_seen <= wr_nx;
            end
        end
    end

    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> !pend_o);                                              // R2
    AST_REARM_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(armed) && $past(en_i)) |-> $past(wr_seen || wr_end_i));  // R6
endmodule

// File: rtl/dreq_xfer_seq.sv
// Module: dreq_xfer_seq
// Runs one read cycle and then one write cycle, each CYC_LEN granted clocks
// long, pulses done, and holds the bus released for REL_CYC clocks.
// A pending request is activated only in idle at a bus-break point.
// Assumes CYC_LEN >= 1 and REL_CYC >= 2.
module dreq_xfer_seq
    import dreq_pkg::*;
#(
    parameter int CYC_LEN = 2,
    parameter int REL_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic en_i,
    input  logic bus_grant,
    input  logic bus_break,
    output logic act_o,
    output logic wr_end_o,
    output logic idle_o,
    output logic rd_o,
    output logic wr_o,
    output logic done_o
);
    localparam int MAXC = (CYC_LEN > REL_CYC) ? CYC_LEN : REL_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t     state;
    logic [CW-1:0]  cnt;
    logic           cyc_last;
    logic           rel_last;

    assign cyc_last = bus_grant && (cnt == CW'(CYC_LEN - 1));
    assign rel_last = (cnt == CW'(REL_CYC - 1));
    assign act_o    = (state == ST_IDLE) && pend_i && bus_break && en_i;
    assign wr_end_o = (state == ST_WRITE) && cyc_last;
    assign idle_o   = (state == ST_IDLE);
    assign rd_o     = (state == ST_READ);
    assign wr_o     = (state == ST_WRITE);

    // Transfer state machine with shared cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (act_o) state <= ST_READ;
                end
                ST_READ: begin
                    if (cyc_last) begin
                        cnt   <= '0;
                        state <= en_i ? ST_WRITE : ST_IDLE;
                    end else if (bus_grant) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (cyc_last) begin
                        cnt   <= '0;
                        state <= ST_REL;
                    end else if (bus_grant) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (rel_last) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // One-clock completion pulse after the final write clock.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= wr_end_o;
    end

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(wr_o));                                         // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                             // R4
    AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_o) |-> !rd_o ##1 !rd_o);                                // R5
endmodule

// File: rtl/dreq_accept_ctrl.sv
// Module: dreq_accept_ctrl (top)
// Turns an active-low asynchronous request pin into single read/write
// transfers for one channel. The pin is synchronized, accepted while open,
// activated at a bus break, and re-armed after a high level and write end.
module dreq_accept_ctrl #(
    parameter int CYC_LEN     = 2,
    parameter int REL_CYC     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dreq_n,
    input  logic xfer_en,
    input  logic bus_grant,
    input  logic bus_break,
    output logic rd_cyc,
    output logic wr_cyc,
    output logic xfer_done
);
    logic req_n_s;
    logic pend;
    logic act;
    logic wr_end;
    logic idle;

    dreq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(dreq_n), .sync_o(req_n_s)
    );

    dreq_accept u_accept (
        .clk(clk), .rst_n(rst_n), .req_n_s(req_n_s), .en_i(xfer_en),
        .idle_i(idle), .act_i(act), .wr_end_i(wr_end), .pend_o(pend)
    );

    dreq_xfer_seq #(.CYC_LEN(CYC_LEN), .REL_CYC(REL_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(xfer_en),
        .bus_grant(bus_grant), .bus_break(bus_break), .act_o(act),
        .wr_end_o(wr_end), .idle_o(idle), .rd_o(rd_cyc), .wr_o(wr_cyc),
        .done_o(xfer_done)
    );

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_cyc && wr_cyc));                                            // R3
    AST_START_AT_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_cyc) |-> ($past(bus_break) && $past(xfer_en)));         // R2
endmodule

// File: tb/test_dreq_accept_ctrl.sv
module test_dreq_accept_ctrl;
    logic clk = 1'b0;
    logic rst_n, dreq_n, xfer_en, bus_grant, bus_break;
    logic rd_cyc, wr_cyc, xfer_done;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    dreq_accept_ctrl i_dreq_accept_ctrl (
        .clk(clk), .rst_n(rst_n), .dreq_n(dreq_n), .xfer_en(xfer_en),
        .bus_grant(bus_grant), .bus_break(bus_break),
        .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .xfer_done(xfer_done)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp, input bit at_least);
        n_cmp++;
        if (at_least ? (act < exp) : (act != exp)) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %s%0d", req, act, at_least ? ">=" : "", exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic en);
        @(negedge clk);
        rst_n = 1'b0; dreq_n = 1'b1; xfer_en = en; bus_grant = 1'b1; bus_break = 1'b1;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    // Counts read starts over n cycles; records index of last done and next read start after it.
    task automatic count_reads(input int n, output int reads, output int gap);
        logic prev = rd_cyc;
        int   done_at = -1;
        reads = 0; gap = -1;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (rd_cyc && !prev) begin
                reads++;
                if (done_at >= 0 && gap < 0) gap = i - done_at;
            end
            if (xfer_done) done_at = i;
            prev = rd_cyc;
        end
    endtask

    task automatic t_reset();
        do_reset(1'b1);
        chk("R1 rd_cyc after reset", rd_cyc, 1'b0);
        chk("R1 wr_cyc after reset", wr_cyc, 1'b0);
        chk("R1 xfer_done after reset", xfer_done, 1'b0);
    endtask

    task automatic t_basic();
        do_reset(1'b1);
        dreq_n = 1'b0;
        tick(3);
        chk("R1 no read before sync latency", rd_cyc, 1'b0);
        tick(1);
        chk("R1 read starts after four edges", rd_cyc, 1'b1);
        tick(1);
        chk("R3 read second clock", rd_cyc, 1'b1);
        chk("R3 no write during read", wr_cyc, 1'b0);
        tick(1);
        chk("R3 write follows read", wr_cyc, 1'b1);
        chk("R3 read ended", rd_cyc, 1'b0);
        tick(1);
        chk("R3 write second clock", wr_cyc, 1'b1);
        chk("R4 no done during write", xfer_done, 1'b0);
        tick(1);
        chk("R4 done after write", xfer_done, 1'b1);
        chk("R3 write ended", wr_cyc, 1'b0);
        tick(1);
        chk("R4 done one clock", xfer_done, 1'b0);
        dreq_n = 1'b1;
        tick(4);
    endtask

    task automatic t_stall();
        do_reset(1'b1);
        dreq_n = 1'b0;
        tick(4);
        chk("R3 read started", rd_cyc, 1'b1);
        bus_grant = 1'b0;
        tick(3);
        chk("R3 read held without grant", rd_cyc, 1'b1);
        chk("R3 no write without grant", wr_cyc, 1'b0);
        bus_grant = 1'b1;
        tick(1);
        chk("R3 read resumes", rd_cyc, 1'b1);
        tick(1);
        chk("R3 write after stalled read", wr_cyc, 1'b1);
        dreq_n = 1'b1;
        tick(6);
    endtask

    task automatic t_no_break();
        do_reset(1'b1);
        bus_break = 1'b0;
        dreq_n = 1'b0;
        tick(10);
        chk("R2 pending waits for bus break", rd_cyc, 1'b0);
        bus_break = 1'b1;
        tick(1);
        chk("R2 read starts at bus break", rd_cyc, 1'b1);
        dreq_n = 1'b1;
        tick(8);
    endtask

    task automatic t_held_low();
        int reads, gap;
        do_reset(1'b1);
        dreq_n = 1'b0;
        count_reads(40, reads, gap);
        chk_int("R6 pin held low gives one transfer", reads, 1, 1'b0);
        dreq_n = 1'b1;
        tick(3);
        dreq_n = 1'b0;
        count_reads(20, reads, gap);
        chk_int("R6 fresh falling edge re-accepted", reads, 1, 1'b0);
        dreq_n = 1'b1;
        tick(4);
    endtask

    task automatic t_release();
        int reads, gap;
        do_reset(1'b1);
        dreq_n = 1'b0;
        tick(4);
        dreq_n = 1'b1;
        tick(1);
        dreq_n = 1'b0;
        count_reads(30, reads, gap);
        chk_int("R6 second request after high seen", reads, 1, 1'b0);
        chk_int("R5 release gap after done", gap, 3, 1'b1);
        dreq_n = 1'b1;
        tick(6);
    endtask

    task automatic t_disabled();
        int reads, gap;
        do_reset(1'b0);
        dreq_n = 1'b0;
        count_reads(20, reads, gap);
        chk_int("R7 disabled channel ignores pin", reads, 0, 1'b0);
        chk("R7 no write when disabled", wr_cyc, 1'b0);
        dreq_n = 1'b1;
        tick(4);
    endtask

    task automatic t_abort();
        bit saw_wr = 1'b0, saw_done = 1'b0;
        do_reset(1'b1);
        dreq_n = 1'b0;
        tick(4);
        chk("R8 read started", rd_cyc, 1'b1);
        xfer_en = 1'b0;
        tick(1);
        chk("R8 read completes", rd_cyc, 1'b1);
        tick(1);
        chk("R8 idle after aborted read", rd_cyc, 1'b0);
        for (int i = 0; i < 10; i++) begin
            if (wr_cyc) saw_wr = 1'b1;
            if (xfer_done) saw_done = 1'b1;
            tick(1);
        end
        chk("R8 no write after abort", saw_wr, 1'b0);
        chk("R8 no done after abort", saw_done, 1'b0);
        dreq_n = 1'b1;
        tick(4);
    endtask

    initial begin
        rst_n = 1'b0; dreq_n = 1'b1; xfer_en = 1'b1; bus_grant = 1'b1; bus_break = 1'b1;
        t_reset();
        t_basic();
        t_stall();
        t_no_break();
        t_held_low();
        t_release();
        t_disabled();
        t_abort();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule